// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a processor's memory port and its instruction decoder. It keeps a 20-bit code fetch pointer and reads code bytes ahead of the consumer, one byte per memory transaction. Each byte is stored in a small FIFO. The decoder takes bytes from the head of that FIFO through a valid/ready handshake. While the FIFO has a free slot, the fetch engine keeps issuing reads, so the decoder rarely has to wait for memory.

A taken jump drives the flush input together with a new target address. The flush empties the FIFO and moves the fetch pointer to the target. A memory read that is still in progress is allowed to finish, but its byte is thrown away. The FIFO depth is four bytes for the narrow-bus build and six bytes for the wide-bus build, selected by a single parameter.

Top module: `code_prefetch_q`

## Requirements
- R1: While reset is held, mem_req_o and out_valid_o are 0. After reset, the first read is issued at address BOOT_ADDR (default 20'hFFFF0).
- R2: Bytes reach out_data_o in the order in which their reads were issued. A byte leaves the FIFO only on a cycle where out_valid_o and out_ready_i are both 1.
- R3: The number of stored bytes plus the one read in flight never exceeds DEPTH (4 when WIDE_BUS=0, 6 when WIDE_BUS=1). With the consumer stalled, exactly DEPTH reads complete and then mem_req_o falls to 0.
- R4: A read completes on a clock edge where mem_req_o and mem_ready_i are both 1, and mem_data_i is captured on that edge. While mem_ready_i is 0, mem_req_o stays 1 and mem_addr_o does not change.
- R5: Consecutive reads with no flush between them use addresses that increase by one, wrapping from 20'hFFFFF to 20'h00000.
- R6: When a read completes and the FIFO will still have room, the next read starts on the same edge. mem_req_o therefore stays high continuously while the decoder drains one byte per cycle and memory answers at once.
- R7: One cycle after flush_i, out_valid_o is 0. Every byte delivered afterwards comes from flush_addr_i and the addresses that follow it.
- R8: If a read is still in progress when flush_i is asserted, it stays on the bus at its old address until it completes. Its byte is then discarded, and the first read from the new address starts on that same edge.
- R9: A push and a pop on the same edge leave the occupancy unchanged. With back-to-back traffic, out_valid_o stays high every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Discard queued code and redirect fetching |
| flush_addr_i | input | 20 | New fetch address loaded on flush |
| mem_req_o | output | 1 | Byte read request, held until accepted |
| mem_addr_o | output | 20 | Byte address of the current read |
| mem_ready_i | input | 1 | Memory returns data this cycle |
| mem_data_i | input | 8 | Returned code byte |
| out_valid_o | output | 1 | Head of the queue holds a byte |
| out_data_o | output | 8 | Byte at the head of the queue |
| out_ready_i | input | 1 | Decoder takes the head byte |

## Verification
The assertions check the following on every cycle:
- the occupancy bound, with the in-flight read counted;
- that a waiting request stays stable;
- the address step from one read to the next;
- that the FIFO is empty after a flush;
- that no byte is pushed from a discarded read;
- that the count is unchanged on a simultaneous push and pop.

Some properties depend on whole byte streams and can only be shown by the bench scenarios. These are the order and values of the delivered bytes, the exact number of reads issued against a stalled decoder, the wrap of the address at the top of the space, and the redirect after a flush that lands in the middle of a slow read.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int CODE_AW = 20;
  localparam int CODE_DW = 8;

  typedef logic [CODE_AW-1:0] code_addr_t;
  typedef logic [CODE_DW-1:0] code_byte_t;

  // queue depth chosen by external bus width
  function automatic int depth_for(input bit wide_bus);
    return wide_bus ? 6 : 4;
  endfunction

  // sequential code address, wraps across the 1 MiB space
  function automatic code_addr_t step_addr(input code_addr_t a);
    return a + code_addr_t'(1);
  endfunction

  // occupancy after the current edge
  function automatic int occ_after(input int cnt, input bit push, input bit pop);
    return cnt + int'(push) - int'(pop);
  endfunction
endpackage

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                push,
  input  pfq_pkg::code_byte_t din,
  input  logic                pop,
  output pfq_pkg::code_byte_t dout,
  output logic [CNT_W-1:0]    count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pfq_pkg::code_byte_t    store [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout = store[rd_ptr];
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter logic [19:0] BOOT_ADDR = 20'hFFFF0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  pfq_pkg::code_addr_t flush_addr,
  input  logic                slot_free,
  input  logic                mem_ready,
  output logic                mem_req,
  output pfq_pkg::code_addr_t mem_addr,
  output logic                start_o,
  output logic                done_o,
  output logic                drop_o,
  output logic                deliver_o
);
  logic                pend;
  logic                drop;
  pfq_pkg::code_addr_t ptr;
  pfq_pkg::code_addr_t req_addr;

  assign done_o    = pend && mem_ready;
  assign deliver_o = done_o && !drop && !flush;
  assign start_o   = (!pend || done_o) && slot_free && !flush;
  assign drop_o    = drop;
  assign mem_req   = pend;
  assign mem_addr  = req_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      drop     <= 1'b0;
      ptr      <= BOOT_ADDR;
      req_addr <= BOOT_ADDR;
    end else begin
      if (done_o) pend <= 1'b0;
      if (start_o) begin
        pend     <= 1'b1;
        req_addr <= ptr;
        ptr      <= pfq_pkg::step_addr(ptr);
      end
      if (flush) begin
        ptr  <= flush_addr;
        drop <= pend && !done_o;
      end else if (done_o) begin
        drop <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/code_prefetch_q.sv
module code_prefetch_q #(
  parameter bit          WIDE_BUS  = 1'b0,
  parameter logic [19:0] BOOT_ADDR = 20'hFFFF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush_i,
  input  logic [19:0] flush_addr_i,
  output logic        mem_req_o,
  output logic [19:0] mem_addr_o,
  input  logic        mem_ready_i,
  input  logic [7:0]  mem_data_i,
  output logic        out_valid_o,
  output logic [7:0]  out_data_o,
  input  logic        out_ready_i
);
  localparam int DEPTH = pfq_pkg::depth_for(WIDE_BUS);
  localparam int CNT_W = $clog2(DEPTH + 1);

  // named internal events, also observed by the checker
  logic             fetch_start;
  logic             fetch_done;
  logic             fetch_drop;
  logic             fifo_push;
  logic             fifo_pop;
  logic             slot_free;
  logic [CNT_W-1:0] fifo_count;

  assign out_valid_o = (fifo_count != '0);
  assign fifo_pop    = out_valid_o && out_ready_i;
  assign slot_free   = pfq_pkg::occ_after(int'(fifo_count), fifo_push, fifo_pop) < DEPTH;

  pfq_fetch #(.BOOT_ADDR(BOOT_ADDR)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_i),
    .flush_addr (flush_addr_i),
    .slot_free  (slot_free),
    .mem_ready  (mem_ready_i),
    .mem_req    (mem_req_o),
    .mem_addr   (mem_addr_o),
    .start_o    (fetch_start),
    .done_o     (fetch_done),
    .drop_o     (fetch_drop),
    .deliver_o  (fifo_push)
  );

  pfq_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (flush_i),
    .push  (fifo_push),
    .din   (mem_data_i),
    .pop   (fifo_pop),
    .dout  (out_data_o),
    .count (fifo_count)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             mem_req,
  input logic             mem_ready,
  input logic [19:0]      mem_addr,
  input logic             out_valid,
  input logic [CNT_W-1:0] count,
  input logic             fetch_start,
  input logic             fetch_done,
  input logic             fetch_drop,
  input logic             push,
  input logic             pop
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R3
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) + int'(mem_req) <= DEPTH); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr)); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done && fetch_start && !fetch_drop |=> mem_addr == $past(mem_addr) + 20'd1); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R7
  AST_DROP_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_drop && mem_ready |-> !push); // R8
  AST_HOLD_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !flush |=> count == $past(count)); // R9
endmodule

bind code_prefetch_q pfq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush_i),
  .mem_req     (mem_req_o),
  .mem_ready   (mem_ready_i),
  .mem_addr    (mem_addr_o),
  .out_valid   (out_valid_o),
  .count       (fifo_count),
  .fetch_start (fetch_start),
  .fetch_done  (fetch_done),
  .fetch_drop  (fetch_drop),
  .push        (fifo_push),
  .pop         (fifo_pop)
);

// File: tb/sim_code_prefetch_q.sv
module sim_code_prefetch_q;
  localparam int          DEPTH_EXP = 4;
  localparam logic [19:0] BOOT      = 20'hFFFF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_i = 1'b0;
  logic [19:0] flush_addr_i = '0;
  logic        mem_req_o;
  logic [19:0] mem_addr_o;
  logic        mem_ready_i = 1'b0;
  logic [7:0]  mem_data_i = '0;
  logic        out_valid_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  code_prefetch_q #(.WIDE_BUS(1'b0), .BOOT_ADDR(BOOT)) u0 (.*);

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return (a[7:0] ^ {a[11:8], a[19:16]}) + 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard and memory model state
  logic [7:0]  exp_q[$];
  logic [19:0] nxt_fa = BOOT;
  logic [19:0] old_addr = '0;
  logic [19:0] wait_addr = '0;
  int          lat = 0;
  int          wcnt = 0;
  int          acc_cnt = 0;
  bit          skip = 0, chk_hold = 0, saw_drop = 0, prev_flush = 0, was_wait = 0;

  // driver: queue the bytes expected from a run of addresses
  task automatic expect_stream(input logic [19:0] a, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(mem_byte(a + 20'(i)));
  endtask

  task automatic wait_empty();
    while (exp_q.size() != 0) @(posedge clk);
    #5;
  endtask

  task automatic flush_to(input logic [19:0] a);
    @(posedge clk); #5;
    flush_i = 1'b1; flush_addr_i = a;
    @(posedge clk); #5;
    flush_i = 1'b0;
  endtask

  // monitor, consumer and memory model, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit rdy;
      logic [7:0] e;
      out_ready_i = (exp_q.size() > 0) && !flush_i;
      if (prev_flush)
        chk(!out_valid_o, "R7", "valid after flush", 32'(out_valid_o), 0);
      if (chk_hold) begin
        chk(mem_req_o && mem_addr_o == old_addr, "R8", "old read held after flush",
            32'(mem_addr_o), 32'(old_addr));
        chk_hold = 0;
      end
      if (out_valid_o && out_ready_i) begin
        e = exp_q.pop_front();
        chk(out_data_o == e, "R2", "byte order/value", 32'(out_data_o), 32'(e));
      end
      if (was_wait)
        chk(mem_req_o && mem_addr_o == wait_addr, "R4", "request held while waiting",
            32'(mem_addr_o), 32'(wait_addr));
      rdy = 0;
      if (mem_req_o) begin
        rdy = (wcnt >= lat);
        wcnt = rdy ? 0 : wcnt + 1;
      end else wcnt = 0;
      if (mem_req_o && rdy) begin
        acc_cnt++;
        if (skip) skip = 0;
        else begin
          chk(mem_addr_o == nxt_fa, "R5", "read address sequence", 32'(mem_addr_o), 32'(nxt_fa));
          nxt_fa = nxt_fa + 20'd1;
        end
      end
      was_wait = mem_req_o && !rdy;
      wait_addr = mem_addr_o;
      if (flush_i) begin
        nxt_fa = flush_addr_i;
        skip = mem_req_o && !rdy;
        if (skip) begin chk_hold = 1; old_addr = mem_addr_o; saw_drop = 1; end
        exp_q.delete();
      end
      prev_flush = flush_i;
      mem_ready_i = rdy;
      mem_data_i = rdy ? mem_byte(mem_addr_o) : 8'h00;
    end
  end

  task automatic run_tests();
    logic [19:0] cur;
    int bad;
    // R1: reset state
    repeat (3) @(posedge clk);
    #5;
    chk(!mem_req_o, "R1", "req in reset", 32'(mem_req_o), 0);
    chk(!out_valid_o, "R1", "valid in reset", 32'(out_valid_o), 0);
    rst_n = 1'b1;
    @(posedge clk); #5;
    chk(mem_req_o && mem_addr_o == BOOT, "R1", "first read address", 32'(mem_addr_o), 32'(BOOT));

    // R3: consumer stalled, slow memory
    lat = 2;
    repeat (30) @(posedge clk);
    #5;
    chk(acc_cnt == DEPTH_EXP, "R3", "reads against stalled consumer", 32'(acc_cnt), DEPTH_EXP);
    chk(!mem_req_o, "R3", "req low when full", 32'(mem_req_o), 0);
    chk(out_valid_o, "R3", "valid when full", 32'(out_valid_o), 1);

    // R2/R4: drain with waiting memory
    cur = BOOT;
    expect_stream(cur, 10); cur = cur + 20'd10;
    wait_empty();

    // R6/R9: zero-latency streaming across the address wrap
    lat = 0;
    expect_stream(cur, 40); cur = cur + 20'd40;
    repeat (10) @(posedge clk);
    #5;
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (!mem_req_o) bad++;
      @(posedge clk); #5;
    end
    chk(bad == 0, "R6", "req gaps while streaming", 32'(bad), 0);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      if (!out_valid_o) bad++;
      @(posedge clk); #5;
    end
    chk(bad == 0, "R9", "valid gaps while streaming", 32'(bad), 0);
    wait_empty();

    // R5/R7: flush to the top of the space, then wrap
    flush_to(20'hFFFFE);
    expect_stream(20'hFFFFE, 8);
    wait_empty();

    // R8: flush in the middle of a slow read
    lat = 5;
    expect_stream(20'hFFFFE + 20'd8, 3);
    wait_empty();
    repeat (2) @(posedge clk);
    flush_to(20'h12345);
    expect_stream(20'h12345, 6);
    wait_empty();
    chk(saw_drop, "R8", "outstanding read dropped", 32'(saw_drop), 1);
    chk(exp_q.size() == 0, "R7", "stream after flush complete", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule